// File: doc/BRIEF.md
# Parameter Page Field Decoder

This block sits behind the part of a flash controller that has already fetched one copy of a NAND parameter page and confirmed its CRC. It watches that page go past one byte at a time, each byte with its index, and keeps only the fields it needs: revision, features, extended page length, copy count, memory organisation, bad-block limit, endurance, partial-program count and ECC requirement. When the page-end beat arrives it stops accepting bytes and works out the derived values over a fixed number of cycles. It then raises `dec_done` for one cycle, during which every decoded output and error flag is valid.

The input is a valid/ready stream. A beat transfers on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` is high while the block is collecting bytes and low from the edge that takes the end beat (`in_last`) until the computation finishes. A source that keeps `in_valid` high during that window just stalls. Bytes may arrive with idle cycles between them. Only the index decides which field a byte lands in, and indices that belong to no field are dropped. The cycle after `dec_done`, every captured field returns to zero, so a field that the next page never carries decodes as zero.

Top module: `param_page_decoder`

## Requirements
- R1: `in_ready` is high after reset and whenever the block is collecting. It goes low on the edge that accepts a beat with `in_last` set and comes back high on the edge that ends the `dec_done` cycle. A byte offered with `in_valid` low never changes any field.
- R2: `dec_done` is high for exactly one cycle. That cycle is the one after the tenth rising edge following the edge that accepted the end beat.
- R3: `err_signature` is set unless bytes 0..3 are 4Fh, 4Eh, 46h and 49h, in that order.
- R4: The revision word is bytes 4 (low) and 5 (high). If bit 0 is set, `err_rev_invalid` is set and `rev_code` is 0. Otherwise `rev_code` is the highest set bit among bits 1..5 of the word. If none of those bits is set, `rev_code` is 0 and `err_rev_unsupported` is set.
- R5: Byte 6 bit 0 gives `bus_is_16`. Byte 6 bit 7 marks an extended page. `ext_page_bytes` is the little-endian word in bytes 12..13 multiplied by 16.
- R6: `page_copies` is byte 14 when `rev_code` is 3 or more. Otherwise it is 3.
- R7: `page_bytes` (bytes 80..83), `spare_bytes` (84..85), `pages_per_blk` (92..95) and `part_programs` (byte 110) are passed out as little-endian values.
- R8: `total_blocks` is the low 24 bits of the blocks-per-unit word (bytes 96..99) times the unit count (byte 100). `bad_blk_limit` is the word in bytes 103..104 times the unit count.
- R9: `endurance` is the low 32 bits of byte 105 times 10 to the power of byte 106. If byte 106 is above 9, `endurance` is byte 105 alone and `err_incompat` is set. If the true product is 2^32 or more, `err_incompat` is also set.
- R10: `err_incompat` is set if page size ≥ 2^16, pages per block ≥ 2^16, or blocks per unit ≥ 2^24.
- R11: Byte 112 is `ecc_bits`. If it is FFh, `ecc_in_ext` is set and `ecc_codeword` is 0, and `err_no_ext` is set when no extended page is marked. For any other value, `ecc_codeword` is 528.
- R12: After `dec_done`, every captured field is zero. A page that ends early decodes all of its missing fields as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Byte beat offered |
| in_ready | output | 1 | Block accepts a beat |
| in_data | input | 8 | Page byte |
| in_idx | input | IDX_W | Byte index within the page |
| in_last | input | 1 | Beat is the end of the page |
| dec_done | output | 1 | Outputs valid this cycle |
| page_bytes | output | 32 | Data bytes per page |
| spare_bytes | output | 16 | Spare bytes per page |
| pages_per_blk | output | 32 | Pages per block |
| total_blocks | output | BLK_W+8 | Blocks per unit times unit count |
| bad_blk_limit | output | 24 | Bad-block limit times unit count |
| endurance | output | 32 | Mantissa times ten to the exponent |
| part_programs | output | 8 | Partial programs per page |
| bus_is_16 | output | 1 | 16-bit data bus |
| ext_page_bytes | output | 20 | Extended page length in bytes |
| page_copies | output | 8 | Parameter page copies |
| rev_code | output | 4 | Selected revision bit |
| ecc_bits | output | 8 | Correctable bits |
| ecc_codeword | output | 10 | Codeword size, 0 when deferred |
| ecc_in_ext | output | 1 | ECC data is in the extended page |
| err_signature | output | 1 | Signature mismatch |
| err_rev_invalid | output | 1 | Revision bit 0 set |
| err_rev_unsupported | output | 1 | No supported revision bit |
| err_incompat | output | 1 | A value exceeds its width or range |
| err_no_ext | output | 1 | ECC deferred but no extended page |

## Verification
The bench probes the endurance edges. One page uses exponent 9 with a product that still fits in 32 bits, one crosses 2^32, and one uses exponent 10. A decoder that scaled one step too many or too few, or dropped the sticky overflow, would report the wrong endurance or a wrong `err_incompat`. Revision words with only bit 6 set, or with bit 0 set next to valid bits, catch a priority encoder that reaches past its top bit or ignores the invalid bit. A short page sent with idle gaps carrying junk bytes shows the difference between a block that clears its fields after each page and captures only on a handshake, and one that leaks the previous page's geometry or the junk into the result.

// File: rtl/pp_dec_pkg.sv
package pp_dec_pkg;

  localparam int NUM_FIELDS = 15;

  typedef enum logic [3:0] {
    FLD_SIG, FLD_REV, FLD_FEAT, FLD_XLEN, FLD_COPY,
    FLD_PGSZ, FLD_SPARE, FLD_PPB, FLD_BPL, FLD_LUN,
    FLD_BAD, FLD_ENDV, FLD_ENDX, FLD_PPP, FLD_ECC
  } fld_e;

  typedef enum logic [1:0] {ST_COLLECT, ST_CALC, ST_FIN} dec_st_e;

  // Signature bytes 'O','N','F','I' read little-endian
  localparam logic [31:0] SIG_WORD = 32'h4946_4E4F;

  function automatic int fld_base(int f);
    case (f)
      0: return 0;    1: return 4;    2: return 6;    3: return 12;
      4: return 14;   5: return 80;   6: return 84;   7: return 92;
      8: return 96;   9: return 100;  10: return 103; 11: return 105;
      12: return 106; 13: return 110; default: return 112;
    endcase
  endfunction

  function automatic int fld_len(int f);
    case (f)
      0, 5, 7, 8: return 4;
      1, 3, 6, 10: return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/pp_field_bank.sv
module pp_field_bank
  import pp_dec_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            wr,
  input  logic [IDX_W-1:0]                idx,
  input  logic [7:0]                      data,
  output logic [NUM_FIELDS-1:0][31:0]     fields
);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam int BASE = fld_base(g);
    localparam int LEN  = fld_len(g);
    logic [IDX_W:0] off;
    logic           hit;
    logic [31:0]    val;

    assign off = {1'b0, idx} - (IDX_W+1)'(BASE);
    assign hit = wr && (off < (IDX_W+1)'(LEN));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val <= '0;
      else if (clr) val <= '0;
      else if (hit) val[{off[1:0], 3'b000} +: 8] <= data;
    end

    assign fields[g] = val;
  end

endmodule

// File: rtl/pp_serial_mul.sv
module pp_serial_mul #(
  parameter int AW = 24,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] prod
);

  logic [AW+BW-1:0] acc, mcand;
  logic [BW-1:0]    mpl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      mcand <= '0;
      mpl   <= '0;
    end else if (load) begin
      acc   <= '0;
      mcand <= {{BW{1'b0}}, a};
      mpl   <= b;
    end else if (step) begin
      if (mpl[0]) acc <= acc + mcand;
      mcand <= mcand << 1;
      mpl   <= mpl >> 1;
    end
  end

  assign prod = acc;

endmodule

// File: rtl/pp_pow10_scale.sv
module pp_pow10_scale #(
  parameter int MW   = 8,
  parameter int EW   = 8,
  parameter int MAXE = 9,
  parameter int OW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [MW-1:0] mant,
  input  logic [EW-1:0] expo,
  output logic [OW-1:0] value,
  output logic          ovf,
  output logic          exp_bad
);

  localparam int AW = OW + 4;
  localparam int CW = $clog2(MAXE + 1);

  logic [AW-1:0] acc, nxt;
  logic [CW-1:0] left;

  assign nxt = (acc << 3) + (acc << 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      left    <= '0;
      ovf     <= 1'b0;
      exp_bad <= 1'b0;
    end else if (load) begin
      acc     <= AW'(mant);
      ovf     <= 1'b0;
      exp_bad <= (expo > EW'(MAXE));
      left    <= (expo > EW'(MAXE)) ? '0 : CW'(expo);
    end else if (step && left != '0) begin
      acc  <= nxt;
      left <= left - 1'b1;
      if (nxt[AW-1:OW] != '0) ovf <= 1'b1;
    end
  end

  assign value = acc[OW-1:0];

endmodule

// File: rtl/param_page_decoder.sv
module param_page_decoder
  import pp_dec_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int PG_W     = 16,
  parameter int PPB_W    = 16,
  parameter int BLK_W    = 24,
  parameter int VER_TOP  = 5,
  parameter int COPY_REV = 3,
  parameter int MAX_EXP  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic [IDX_W-1:0]   in_idx,
  input  logic               in_last,
  output logic               dec_done,
  output logic [31:0]        page_bytes,
  output logic [15:0]        spare_bytes,
  output logic [31:0]        pages_per_blk,
  output logic [BLK_W+7:0]   total_blocks,
  output logic [23:0]        bad_blk_limit,
  output logic [31:0]        endurance,
  output logic [7:0]         part_programs,
  output logic               bus_is_16,
  output logic [19:0]        ext_page_bytes,
  output logic [7:0]         page_copies,
  output logic [3:0]         rev_code,
  output logic [7:0]         ecc_bits,
  output logic [9:0]         ecc_codeword,
  output logic               ecc_in_ext,
  output logic               err_signature,
  output logic               err_rev_invalid,
  output logic               err_rev_unsupported,
  output logic               err_incompat,
  output logic               err_no_ext
);

  localparam int CALC_STEPS = (MAX_EXP > 8) ? MAX_EXP : 8;
  localparam int CNT_W      = $clog2(CALC_STEPS + 1);

  dec_st_e                    st;
  logic [CNT_W-1:0]           cnt;
  logic                       accept, unit_load, unit_step;
  logic [NUM_FIELDS-1:0][31:0] f;
  logic [15:0]                rev;
  logic [7:0]                 feat, lun, ecc;
  logic                       end_ovf, end_exp_bad, geo_over;

  assign in_ready  = (st == ST_COLLECT);
  assign accept    = in_valid && in_ready;
  assign unit_load = (st == ST_CALC) && (cnt == '0);
  assign unit_step = (st == ST_CALC) && (cnt != '0);
  assign dec_done  = (st == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_COLLECT;
      cnt <= '0;
    end else begin
      case (st)
        ST_COLLECT: if (accept && in_last) begin
          st  <= ST_CALC;
          cnt <= '0;
        end
        ST_CALC: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(CALC_STEPS)) st <= ST_FIN;
        end
        default: st <= ST_COLLECT;
      endcase
    end
  end

  pp_field_bank #(.IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(dec_done), .wr(accept),
    .idx(in_idx), .data(in_data), .fields(f)
  );

  assign rev  = f[FLD_REV][15:0];
  assign feat = f[FLD_FEAT][7:0];
  assign lun  = f[FLD_LUN][7:0];
  assign ecc  = f[FLD_ECC][7:0];

  pp_serial_mul #(.AW(BLK_W), .BW(8)) u_blk_mul (
    .clk(clk), .rst_n(rst_n), .load(unit_load), .step(unit_step),
    .a(f[FLD_BPL][BLK_W-1:0]), .b(lun), .prod(total_blocks)
  );

  pp_serial_mul #(.AW(16), .BW(8)) u_bad_mul (
    .clk(clk), .rst_n(rst_n), .load(unit_load), .step(unit_step),
    .a(f[FLD_BAD][15:0]), .b(lun), .prod(bad_blk_limit)
  );

  pp_pow10_scale #(.MW(8), .EW(8), .MAXE(MAX_EXP), .OW(32)) u_endur (
    .clk(clk), .rst_n(rst_n), .load(unit_load), .step(unit_step),
    .mant(f[FLD_ENDV][7:0]), .expo(f[FLD_ENDX][7:0]),
    .value(endurance), .ovf(end_ovf), .exp_bad(end_exp_bad)
  );

  always_comb begin
    rev_code = '0;
    if (!rev[0]) begin
      for (int k = 1; k <= VER_TOP; k++) begin
        if (rev[k]) rev_code = 4'(k);
      end
    end
  end

  assign err_rev_invalid     = rev[0];
  assign err_rev_unsupported = !rev[0] && (rev_code == '0);
  assign err_signature       = (f[FLD_SIG] != SIG_WORD);

  assign bus_is_16      = feat[0];
  assign ext_page_bytes = {f[FLD_XLEN][15:0], 4'b0000};
  assign page_copies    = (rev_code >= 4'(COPY_REV)) ? f[FLD_COPY][7:0] : 8'd3;

  assign page_bytes    = f[FLD_PGSZ];
  assign spare_bytes   = f[FLD_SPARE][15:0];
  assign pages_per_blk = f[FLD_PPB];
  assign part_programs = f[FLD_PPP][7:0];

  assign geo_over = ((f[FLD_PGSZ] >> PG_W) != '0) ||
                    ((f[FLD_PPB] >> PPB_W) != '0) ||
                    ((f[FLD_BPL] >> BLK_W) != '0);
  assign err_incompat = geo_over || end_ovf || end_exp_bad;

  assign ecc_bits     = ecc;
  assign ecc_in_ext   = (ecc == 8'hFF);
  assign ecc_codeword = ecc_in_ext ? 10'd0 : 10'd528;
  assign err_no_ext   = ecc_in_ext && !feat[7];

  logic unused_bits;
  assign unused_bits = ^{rev[15:VER_TOP+1], feat[6:1], f[FLD_REV][31:16],
                         f[FLD_FEAT][31:8], f[FLD_XLEN][31:16], f[FLD_COPY][31:8],
                         f[FLD_SPARE][31:16], f[FLD_LUN][31:8], f[FLD_BAD][31:16],
                         f[FLD_ENDV][31:8], f[FLD_ENDX][31:8], f[FLD_PPP][31:8],
                         f[FLD_ECC][31:8]};

endmodule

// File: rtl/pp_dec_checker.sv
module pp_dec_checker #(
  parameter int COPY_REV = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_last,
  input logic       dec_done,
  input logic [3:0] rev_code,
  input logic [7:0] page_copies,
  input logic [9:0] ecc_codeword,
  input logic       ecc_in_ext,
  input logic       err_rev_invalid,
  input logic       err_rev_unsupported,
  input logic       err_no_ext
);

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready); // R1
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |=> in_ready); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |=> !dec_done); // R2
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> !in_ready); // R2
  AST_REV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && err_rev_invalid |-> !err_rev_unsupported && rev_code == 4'd0); // R4
  AST_OLD_REV_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && rev_code < 4'(COPY_REV) |-> page_copies == 8'd3); // R6
  AST_EXT_NO_CODEWORD: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && ecc_in_ext |-> ecc_codeword == 10'd0); // R11
  AST_NO_EXT_IMPLIES_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && err_no_ext |-> ecc_in_ext); // R11

endmodule

bind param_page_decoder pp_dec_checker #(.COPY_REV(COPY_REV)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .dec_done(dec_done), .rev_code(rev_code),
  .page_copies(page_copies), .ecc_codeword(ecc_codeword),
  .ecc_in_ext(ecc_in_ext), .err_rev_invalid(err_rev_invalid),
  .err_rev_unsupported(err_rev_unsupported), .err_no_ext(err_no_ext)
);

// File: tb/test_param_page_decoder.sv
module test_param_page_decoder;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, in_valid, in_ready, in_last, dec_done;
  logic [7:0]  in_data, in_idx;
  logic [31:0] page_bytes, pages_per_blk, endurance;
  logic [15:0] spare_bytes;
  logic [31:0] total_blocks;
  logic [23:0] bad_blk_limit;
  logic [7:0]  part_programs, page_copies, ecc_bits;
  logic        bus_is_16, ecc_in_ext, err_signature, err_rev_invalid;
  logic        err_rev_unsupported, err_incompat, err_no_ext;
  logic [19:0] ext_page_bytes;
  logic [3:0]  rev_code;
  logic [9:0]  ecc_codeword;

  param_page_decoder i_param_page_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_idx(in_idx), .in_last(in_last), .dec_done(dec_done),
    .page_bytes(page_bytes), .spare_bytes(spare_bytes), .pages_per_blk(pages_per_blk),
    .total_blocks(total_blocks), .bad_blk_limit(bad_blk_limit), .endurance(endurance),
    .part_programs(part_programs), .bus_is_16(bus_is_16), .ext_page_bytes(ext_page_bytes),
    .page_copies(page_copies), .rev_code(rev_code), .ecc_bits(ecc_bits),
    .ecc_codeword(ecc_codeword), .ecc_in_ext(ecc_in_ext), .err_signature(err_signature),
    .err_rev_invalid(err_rev_invalid), .err_rev_unsupported(err_rev_unsupported),
    .err_incompat(err_incompat), .err_no_ext(err_no_ext)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] pg [256];
  int sent_last;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint gb(int i);
    return (i <= sent_last) ? longint'(pg[i]) : 0;
  endfunction

  function automatic longint le(int base, int len);
    longint v = 0;
    for (int k = 0; k < len; k++) v |= gb(base + k) << (8 * k);
    return v;
  endfunction

  task automatic base_page();
    for (int i = 0; i < 256; i++) pg[i] = 8'h00;
    pg[0] = 8'h4F; pg[1] = 8'h4E; pg[2] = 8'h46; pg[3] = 8'h49;
    pg[4] = 8'h02;
    pg[81] = 8'h08; pg[84] = 8'h80; pg[92] = 8'h40;
    pg[97] = 8'h04; pg[100] = 8'h01; pg[103] = 8'h14;
    pg[105] = 8'h01; pg[106] = 8'h05; pg[110] = 8'h04;
  endtask

  // Reference values computed from the requirements, compared in the done cycle
  task automatic compare_all(string name);
    longint rev, code, e, v, prod, endur, bpl, ecc;
    bit ovf, inc;
    rev  = le(4, 2);
    code = 0;
    if (rev[0] == 1'b0) for (int k = 1; k <= 5; k++) if (rev[k]) code = k;
    chk({"R3 signature ", name}, err_signature, le(0, 4) != 64'h49464E4F);
    chk({"R4 rev_invalid ", name}, err_rev_invalid, rev[0]);
    chk({"R4 rev_code ", name}, rev_code, code);
    chk({"R4 rev_unsupported ", name}, err_rev_unsupported, (rev[0] == 0) && code == 0);
    chk({"R5 bus16 ", name}, bus_is_16, gb(6) & 1);
    chk({"R5 ext_len ", name}, ext_page_bytes, le(12, 2) * 16);
    chk({"R6 copies ", name}, page_copies, (code >= 3) ? gb(14) : 3);
    chk({"R7 page_bytes ", name}, page_bytes, le(80, 4));
    chk({"R7 spare ", name}, spare_bytes, le(84, 2));
    chk({"R7 ppb ", name}, pages_per_blk, le(92, 4));
    chk({"R7 part_programs ", name}, part_programs, gb(110));
    bpl = le(96, 4);
    chk({"R8 total_blocks ", name}, total_blocks, (bpl & 64'hFFFFFF) * gb(100));
    chk({"R8 bad_limit ", name}, bad_blk_limit, le(103, 2) * gb(100));
    v = gb(105); e = gb(106); ovf = 0;
    if (e > 9) endur = v;
    else begin
      prod = v;
      for (int k = 0; k < e; k++) prod = prod * 10;
      endur = prod & 64'hFFFFFFFF;
      ovf = (prod >= 64'h100000000);
    end
    inc = (le(80, 4) >= 65536) || (le(92, 4) >= 65536) || (bpl >= 64'h1000000) || (e > 9) || ovf;
    chk({"R9 endurance ", name}, endurance, endur);
    chk({"R9 R10 incompat ", name}, err_incompat, inc);
    ecc = gb(112);
    chk({"R11 ecc_bits ", name}, ecc_bits, ecc);
    chk({"R11 in_ext ", name}, ecc_in_ext, ecc == 255);
    chk({"R11 codeword ", name}, ecc_codeword, (ecc == 255) ? 0 : 528);
    chk({"R11 no_ext ", name}, err_no_ext, (ecc == 255) && ((gb(6) & 8'h80) == 0));
  endtask

  task automatic send_page(string name, int last, bit gaps);
    sent_last = last;
    for (int i = 0; i <= last; i++) begin
      if (gaps && (i % 2 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0; in_idx = 8'(i); in_data = 8'hA5; in_last = 1'b0;
      end
      @(negedge clk);
      chk({"R1 ready while collecting ", name}, in_ready, 1);
      in_valid = 1'b1; in_idx = 8'(i); in_data = pg[i]; in_last = (i == last);
    end
    for (int c = 0; c <= 11; c++) begin
      @(negedge clk);
      if (c == 0) begin
        in_valid = 1'b1; in_idx = 8'd6; in_data = 8'hFF; in_last = 1'b0;
      end
      chk({"R1 ready ", name}, in_ready, (c == 11) ? 1 : 0);
      chk({"R2 done timing ", name}, dec_done, (c == 10) ? 1 : 0);
      if (c == 10) compare_all(name);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_idx = 8'h00; in_last = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", in_ready, 1);
    chk("R2 done in reset", dec_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", in_ready, 1);

    // Baseline geometry, revision bit 1
    base_page();
    send_page("baseline", 255, 1'b0);

    // Newer revision, wide bus, extended page, deferred ECC, exponent 9 that fits
    base_page();
    pg[4] = 8'h1E; pg[6] = 8'h81; pg[12] = 8'h03; pg[14] = 8'h05;
    pg[96] = 8'h00; pg[97] = 8'h08; pg[100] = 8'h04; pg[103] = 8'h28;
    pg[105] = 8'h03; pg[106] = 8'h09; pg[112] = 8'hFF;
    send_page("rev_new_ext", 255, 1'b0);

    // Bad signature, invalid revision, deferred ECC without extended page, exponent 10
    base_page();
    pg[2] = 8'h47; pg[4] = 8'h07; pg[105] = 8'h07; pg[106] = 8'h0A; pg[112] = 8'hFF;
    send_page("errors", 255, 1'b0);

    // Only an unsupported revision bit, endurance overflow past 32 bits
    base_page();
    pg[4] = 8'h40; pg[105] = 8'h05; pg[106] = 8'h09;
    send_page("unsup_ovf", 255, 1'b0);

    // Geometry widths exceeded
    base_page();
    pg[82] = 8'h01; pg[94] = 8'h01; pg[99] = 8'h01; pg[100] = 8'h02;
    send_page("geo_over", 255, 1'b0);

    // Short page with junk on idle cycles: earlier fields must be cleared (R12)
    base_page();
    pg[4] = 8'h04;
    send_page("R12 short", 5, 1'b1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule